// File: doc/BRIEF.md
# Floating-Point Result Rounder

This block is the final rounding step of a binary floating-point datapath. It takes a result that has already been normalised (sign, biased exponent, fraction field), together with the guard and sticky bits that were shifted out below the fraction. It also takes a flag saying the value already overflowed before rounding, and a rounding-mode select. It returns the rounded sign, exponent and fraction, plus an overflow flag and an inexact flag. The widths are parameters and default to single precision.

The decision to add one unit in the last place uses only four bits: the sign, the fraction LSB, the guard bit and the sticky bit, plus the mode. One extra signal changes that decision. It marks the largest finite magnitude, where the exponent is one below all ones and the fraction is all ones. At that value, an exact tie under nearest-even keeps the odd maximum instead of rounding to infinity. Rounding alone never overflows on an exact tie.

The stage is purely combinational. It has no clock, no handshake and no internal state, and its outputs follow its inputs in the same cycle.

Top module: `fp_round_stage`

## Requirements
- R1: The output sign always equals the input sign.
- R2: Mode codes are: 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest-away; codes 5 to 7 act as nearest-even. Toward zero never changes the magnitude when pre-overflow is low.
- R3: Under nearest-even, the magnitude is incremented when guard=1 and (sticky=1 or fraction LSB=1), except in the case of R4.
- R4: Under nearest-even with pre-overflow low, an input equal to the largest finite value (exponent all ones minus one, fraction all ones) with guard=1 and sticky=0 is output unchanged, with overflow=0 and inexact=1.
- R5: Under nearest-even, the largest finite value with guard=1 and sticky=1 rounds to infinity (exponent all ones, fraction zero) with overflow=1.
- R6: Toward minus infinity increments only when sign=1 and (guard or sticky). Toward plus infinity increments only when sign=0 and (guard or sticky).
- R7: Nearest-away increments whenever guard=1.
- R8: An increment that carries out of the fraction field clears the fraction and adds one to the exponent. If the exponent becomes all ones, the output is infinity and overflow=1.
- R9: With pre-overflow high, overflow=1 regardless of guard and sticky. The output is the largest finite value of the input sign for toward zero, for toward minus infinity with sign=0, and for toward plus infinity with sign=1. In every other case the output is infinity.
- R10: Inexact is 1 exactly when guard, sticky or overflow is 1.

Precondition: the input exponent is below all ones whenever pre-overflow is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | EXP_W | Biased exponent of the unrounded result |
| in_frac | input | FRAC_W | Fraction field of the unrounded result |
| in_guard | input | 1 | First bit below the fraction LSB |
| in_sticky | input | 1 | OR of all bits below the guard bit |
| in_pre_ovf | input | 1 | Value overflowed before rounding |
| rnd_mode | input | 3 | Rounding-mode select (see R2) |
| out_sign | output | 1 | Rounded sign |
| out_exp | output | EXP_W | Rounded exponent |
| out_frac | output | FRAC_W | Rounded fraction |
| out_ovf | output | 1 | Overflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
A narrow configuration (3-bit exponent, 2-bit fraction) is swept over every sign, legal exponent, fraction, guard/sticky pair, mode code and pre-overflow value. The sweep separates:
- even from odd LSB ties,
- mid-range carries from carries into infinity,
- the directed modes' dependence on sign.

At the default width, the largest finite value is tried in nearest-even under all four guard/sticky pairs. That separates the kept tie from the sticky-driven overflow and from plain truncation. A carry across the full fraction field is also tried at the default width.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;
  typedef enum logic [2:0] {
    RND_NEAR_EVEN = 3'd0,
    RND_ZERO      = 3'd1,
    RND_DOWN      = 3'd2,
    RND_UP        = 3'd3,
    RND_NEAR_AWAY = 3'd4
  } rnd_mode_e;
endpackage

// File: rtl/fprnd_max_detect.sv
module fprnd_max_detect #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              at_max_o
);
  localparam logic [EXP_W-1:0] TOP_FINITE_EXP = {{(EXP_W-1){1'b1}}, 1'b0};

  // Largest finite magnitude: exponent one below all ones, fraction all ones.
  assign at_max_o = (exp_i == TOP_FINITE_EXP) && (&frac_i);
endmodule

// File: rtl/fprnd_decide.sv
module fprnd_decide
  import fp_round_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       sign_i,
  input  logic       lsb_i,
  input  logic       guard_i,
  input  logic       sticky_i,
  input  logic       at_max_i,
  output logic       inc_o
);
  logic any_low;
  assign any_low = guard_i | sticky_i;

  always_comb begin
    case (mode_i)
      RND_ZERO:      inc_o = 1'b0;
      RND_DOWN:      inc_o = sign_i & any_low;
      RND_UP:        inc_o = ~sign_i & any_low;
      RND_NEAR_AWAY: inc_o = guard_i;
      // Nearest-even: the odd LSB of the top finite value does not break a tie.
      default:       inc_o = guard_i & (sticky_i | (lsb_i & ~at_max_i));
    endcase
  end
endmodule

// File: rtl/fprnd_apply.sv
module fprnd_apply
  import fp_round_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [2:0]        mode_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              inc_i,
  input  logic              pre_ovf_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              ovf_o
);
  localparam int MAG_W = EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] TOP_FINITE_EXP = {{(EXP_W-1){1'b1}}, 1'b0};

  logic [MAG_W-1:0] mag_sum;
  logic             sum_inf;
  logic             keep_finite;

  // One adder over exponent and fraction: a fraction carry lands in the exponent.
  assign mag_sum = {exp_i, frac_i} + MAG_W'(inc_i);
  assign sum_inf = &mag_sum[MAG_W-1:FRAC_W];

  assign keep_finite = (mode_i == RND_ZERO)
                     | ((mode_i == RND_DOWN) & ~sign_i)
                     | ((mode_i == RND_UP)   &  sign_i);

  always_comb begin
    if (pre_ovf_i) begin
      ovf_o  = 1'b1;
      exp_o  = keep_finite ? TOP_FINITE_EXP : '1;
      frac_o = keep_finite ? '1 : '0;
    end else begin
      ovf_o  = sum_inf;
      exp_o  = mag_sum[MAG_W-1:FRAC_W];
      frac_o = mag_sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/fp_round_stage.sv
module fp_round_stage
  import fp_round_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic              in_guard,
  input  logic              in_sticky,
  input  logic              in_pre_ovf,
  input  logic [2:0]        rnd_mode,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac,
  output logic              out_ovf,
  output logic              out_inexact
);
  logic at_max;
  logic do_inc;

  fprnd_max_detect #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_max (
    .exp_i    (in_exp),
    .frac_i   (in_frac),
    .at_max_o (at_max)
  );

  fprnd_decide u_decide (
    .mode_i   (rnd_mode),
    .sign_i   (in_sign),
    .lsb_i    (in_frac[0]),
    .guard_i  (in_guard),
    .sticky_i (in_sticky),
    .at_max_i (at_max),
    .inc_o    (do_inc)
  );

  fprnd_apply #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_apply (
    .mode_i    (rnd_mode),
    .sign_i    (in_sign),
    .exp_i     (in_exp),
    .frac_i    (in_frac),
    .inc_i     (do_inc),
    .pre_ovf_i (in_pre_ovf),
    .exp_o     (out_exp),
    .frac_o    (out_frac),
    .ovf_o     (out_ovf)
  );

  assign out_sign    = in_sign;
  assign out_inexact = in_guard | in_sticky | out_ovf;

  always_comb begin
    AST_TIE_KEEPS_MAX: assert (!(!in_pre_ovf && at_max && in_guard && !in_sticky
                                 && rnd_mode == 3'd0)
                               || (out_exp == in_exp && out_frac == in_frac && !out_ovf)); // R4
    AST_STICKY_TIE_OVERFLOWS: assert (!(!in_pre_ovf && at_max && in_guard && in_sticky
                                        && rnd_mode == 3'd0)
                                      || (out_ovf && (&out_exp) && out_frac == '0)); // R5
    AST_ZERO_MODE_HOLDS: assert (!(!in_pre_ovf && rnd_mode == 3'd1)
                                 || (out_exp == in_exp && out_frac == in_frac)); // R2
    AST_INF_HAS_ZERO_FRAC: assert (!(out_ovf && (&out_exp)) || out_frac == '0); // R8
    AST_PRE_OVF_FLAGS: assert (!in_pre_ovf || (out_ovf && out_inexact)); // R9
  end
endmodule

// File: tb/fp_round_stage_bench.sv
module fp_round_stage_bench;
  localparam int SE = 3, SF = 2;
  localparam int DE = 8, DF = 23;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0;

  logic          s_sign, s_g, s_s, s_pre;
  logic [SE-1:0] s_exp;
  logic [SF-1:0] s_frac;
  logic [2:0]    s_mode;
  logic          so_sign, so_ovf, so_inx;
  logic [SE-1:0] so_exp;
  logic [SF-1:0] so_frac;

  logic          d_sign, d_g, d_s, d_pre;
  logic [DE-1:0] d_exp;
  logic [DF-1:0] d_frac;
  logic [2:0]    d_mode;
  logic          do_sign, do_ovf, do_inx;
  logic [DE-1:0] do_exp;
  logic [DF-1:0] do_frac;

  fp_round_stage #(.EXP_W(SE), .FRAC_W(SF)) u_fp_round_stage (
    .in_sign(s_sign), .in_exp(s_exp), .in_frac(s_frac), .in_guard(s_g),
    .in_sticky(s_s), .in_pre_ovf(s_pre), .rnd_mode(s_mode),
    .out_sign(so_sign), .out_exp(so_exp), .out_frac(so_frac),
    .out_ovf(so_ovf), .out_inexact(so_inx));

  fp_round_stage u_fp_round_stage_wide (
    .in_sign(d_sign), .in_exp(d_exp), .in_frac(d_frac), .in_guard(d_g),
    .in_sticky(d_s), .in_pre_ovf(d_pre), .rnd_mode(d_mode),
    .out_sign(do_sign), .out_exp(do_exp), .out_frac(do_frac),
    .out_ovf(do_ovf), .out_inexact(do_inx));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int maxfin, inf_mag;
    maxfin  = (1 << (SE + SF)) - (1 << SF) - 1;
    inf_mag = maxfin + 1;
    s_sign = 0; s_exp = 0; s_frac = 0; s_g = 0; s_s = 0; s_pre = 0; s_mode = 0;
    d_sign = 0; d_exp = 0; d_frac = 0; d_g = 0; d_s = 0; d_pre = 0; d_mode = 0;
    @(negedge clk);
    check("R1 zero input", {so_sign, so_exp, so_frac, so_ovf, so_inx}, 0);

    // Exhaustive sweep of the narrow configuration.
    for (int v = 0; v < 2 * 7 * 4 * 4 * 8 * 2; v++) begin
      int sg, e, f, g, st, m, p, mag, lsb, inc, r, ovf, eff, got;
      string tag;
      sg = v & 1; e = (v >> 1) % 7; f = (v / 14) & 3; g = (v / 56) & 1;
      st = (v / 112) & 1; m = (v / 224) & 7; p = (v / 1792) & 1;
      @(posedge clk);
      s_sign = sg[0]; s_exp = e[SE-1:0]; s_frac = f[SF-1:0];
      s_g = g[0]; s_s = st[0]; s_mode = m[2:0]; s_pre = p[0];
      mag = e * 4 + f; lsb = f & 1; eff = (m > 4) ? 0 : m;
      case (eff)
        0: inc = g & (st | (lsb & ((mag != maxfin) ? 1 : 0)));
        1: inc = 0;
        2: inc = sg & (g | st);
        3: inc = (1 - sg) & (g | st);
        default: inc = g;
      endcase
      if (p != 0) begin
        ovf = 1;
        r = (eff == 1 || (eff == 2 && sg == 0) || (eff == 3 && sg == 1)) ? maxfin : inf_mag;
        tag = "R9";
      end else begin
        r = mag + inc; ovf = (r == inf_mag) ? 1 : 0;
        if (eff == 1) tag = "R2";
        else if (mag == maxfin && eff == 0 && g == 1) tag = st ? "R5" : "R4";
        else if (inc == 1 && f == 3) tag = "R8";
        else if (eff == 0) tag = "R3";
        else if (eff == 4) tag = "R7";
        else tag = "R6";
      end
      @(negedge clk);
      got = {so_exp, so_frac};
      check({tag, " magnitude"}, got, r);
      check({tag, " overflow"}, so_ovf, ovf);
      check("R10 inexact", so_inx, (g | st | ovf) != 0);
      check("R1 sign", so_sign, sg);
    end

    // Default width: largest finite value under nearest-even.
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      d_sign = 0; d_exp = 8'hFE; d_frac = '1; d_g = k[1]; d_s = k[0];
      d_mode = 3'd0; d_pre = 0;
      @(negedge clk);
      if (k == 2) begin
        check("R4 tie kept exp", do_exp, 8'hFE);
        check("R4 tie kept frac", do_frac, 23'h7FFFFF);
        check("R4 tie no ovf", do_ovf, 0);
        check("R4 tie inexact", do_inx, 1);
      end else if (k == 3) begin
        check("R5 to inf exp", do_exp, 8'hFF);
        check("R5 to inf frac", do_frac, 0);
        check("R5 ovf", do_ovf, 1);
      end else begin
        check("R3 max no round", {do_exp, do_frac}, {8'hFE, 23'h7FFFFF});
        check("R10 inexact max", do_inx, k[0]);
      end
    end
    @(posedge clk);
    d_exp = 8'd10; d_frac = '1; d_g = 1; d_s = 1; d_mode = 3'd0;
    @(negedge clk);
    check("R8 wide carry", {do_exp, do_frac}, {8'd11, 23'd0});
    @(posedge clk);
    d_pre = 1; d_sign = 1; d_mode = 3'd3;
    @(negedge clk);
    check("R9 wide saturate", {do_sign, do_exp, do_frac, do_ovf}, {1'b1, 8'hFE, 23'h7FFFFF, 1'b1});
    summary();
  end
endmodule